// File: doc/BRIEF.md
# Pipelined Fan-in-Limited Binary Encoder

This block turns a bank of 2^CODE_W request lines into a CODE_W-bit index and a qualifying valid flag. A build-time switch picks one of two behaviours: a priority encoder, where any mix of lines may be high and the highest-numbered high line is reported, or a strict one-hot encoder, where the result is valid only if exactly one line is high. It suits request arbitration in front of a core, or turning a one-hot select back into a binary address.

The logic is a reduction tree. Each node merges at most MAX_FANIN children; inputs that fall beyond a group are tied to the neutral value, so they have no effect. When the line count is larger than MAX_FANIN, the tree grows extra levels. A register stage can be placed after every PIPE_LEVEL tree levels. The leaf lines can optionally be registered on entry, and the result can optionally be registered on exit. Index and valid bits travel together as one record through the same stages, so every output bit has the same latency.

The pipeline takes a new vector on every clock and has no back-pressure: there is no ready signal, and results leave a fixed number of cycles after the inputs are sampled. An optional enable, sampled together with the lines, blanks the vector it goes with.

Top module: `tree_encoder`

## Requirements
- R1: With PRIORITY=1, the result for a vector has valid=1 and code equal to the index of the highest-numbered high line whenever at least one line is high. For four lines this gives: line 0 alone → 0; highest high line 1, 2 or 3 → 1, 2 or 3. No line high gives valid=0.
- R2: With PRIORITY=0, valid=1 only when exactly one line is high, and code is then that line's index. Zero high lines, or two or more, give valid=0.
- R3: Whenever valid_o is 0, code_o is all zeros.
- R4: Each vector's result appears exactly LATENCY rising edges after the vector is sampled. LATENCY = IN_REG + OUT_REG + ceil(D/PIPE_LEVEL), or IN_REG + OUT_REG when PIPE_LEVEL=0. D is the number of tree levels needed to reduce 2^CODE_W lines by a factor MAX_FANIN per level. A new vector is accepted on every cycle, and all output bits change on the same edge.
- R5: With HAS_EN=1, a vector sampled while en is 0 yields code 0 and valid=0, and the vectors before and after it are still processed normally. With HAS_EN=0, en has no effect on the result.
- R6: While rst_n is low, every register stage clears, so a design with LATENCY>0 shows valid_o=0 and code_o=0 until the first vector sampled after reset has come through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_lines | input | 2^CODE_W | Request lines; bit i is line i |
| en | input | 1 | Enable for the vector sampled this cycle (used only if HAS_EN=1) |
| code_o | output | CODE_W | Encoded index |
| valid_o | output | 1 | Result qualifier |

## Verification
The bench goes after the highest-index rule at both ends of the vector and with the top line high alongside lower ones. A tree that picked the lowest child, or merged groups in the wrong order, would report the wrong line. In strict mode it applies zero, two and all lines high: a design that only ORed indices would raise valid, or leak a nonzero code. A back-to-back stream with a known LATENCY, plus a single vector watched one cycle early, would expose a misplaced or missing stage, or results that come out a cycle early or late. Blanked vectors placed between live ones would show an enable that stalled the pipeline or was sampled in the wrong cycle.

// File: rtl/enc_pkg.sv
package enc_pkg;

  // Levels needed to reduce `leaves` items to one with `fanin`-input nodes.
  function automatic int tree_depth(input int leaves, input int fanin);
    int w;
    int d;
    w = leaves;
    d = 0;
    while (w > 1) begin
      w = (w + fanin - 1) / fanin;
      d++;
    end
    return d;
  endfunction

  // Item count present at the input of tree level `lvl`.
  function automatic int level_width(input int leaves, input int fanin, input int lvl);
    int w;
    w = leaves;
    for (int i = 0; i < lvl; i++) w = (w + fanin - 1) / fanin;
    return w;
  endfunction

  // A level is followed by a register every `pipe` levels, and the last one
  // also closes a partial group so the count is ceil(depth/pipe).
  function automatic bit stage_has_reg(input int lvl, input int depth, input int pipe);
    if (pipe <= 0) return 1'b0;
    return (((lvl + 1) % pipe) == 0) || (lvl == depth - 1);
  endfunction

  function automatic int pipe_regs(input int depth, input int pipe);
    if (pipe <= 0) return 0;
    return (depth + pipe - 1) / pipe;
  endfunction

endpackage

// File: rtl/enc_stage_reg.sv
module enc_stage_reg #(
  parameter int WIDTH   = 1,
  parameter bit USE_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (USE_REG) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= d_i;
      end
    end else begin : g_wire
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_o = d_i;
    end
  endgenerate

endmodule

// File: rtl/enc_node.sv
// One tree node: merges up to FANIN child records {any, multi, idx}.
// Children are ordered by line index, so the last active child is the highest.
module enc_node #(
  parameter int CODE_W   = 3,
  parameter int FANIN    = 2,
  parameter int PRIORITY = 1,
  localparam int NW      = CODE_W + 2
) (
  input  logic [FANIN*NW-1:0] kids_i,
  output logic [NW-1:0]       node_o
);

  logic              any_q;
  logic              multi_q;
  logic [CODE_W-1:0] idx_q;
  logic [NW-1:0]     kid;

  always_comb begin
    any_q   = 1'b0;
    multi_q = 1'b0;
    idx_q   = '0;
    kid     = '0;
    for (int c = 0; c < FANIN; c++) begin
      kid = kids_i[c*NW +: NW];
      if (kid[NW-2]) multi_q = 1'b1;
      if (kid[NW-1]) begin
        if (any_q) multi_q = 1'b1;
        any_q = 1'b1;
        if (PRIORITY != 0) idx_q = kid[CODE_W-1:0];
        else               idx_q = idx_q | kid[CODE_W-1:0];
      end
    end
    node_o = {any_q, multi_q, idx_q};
  end

endmodule

// File: rtl/enc_reduce_tree.sv
module enc_reduce_tree #(
  parameter int CODE_W     = 3,
  parameter int FANIN      = 2,
  parameter int PIPE_LEVEL = 1,
  parameter int PRIORITY   = 1,
  localparam int LEAVES    = 1 << CODE_W,
  localparam int NW        = CODE_W + 2,
  localparam int DEPTH     = enc_pkg::tree_depth(LEAVES, FANIN),
  localparam int SPAN      = LEAVES + FANIN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LEAVES*NW-1:0] leaves_i,
  output logic [NW-1:0]        root_o
);

  // Every level bus is sized for the widest level plus one spare group, so
  // the last node of a level reads zeros (the neutral value) past its end.
  logic [DEPTH:0][SPAN*NW-1:0] lvl;
  logic unused_bits;

  assign lvl[0][LEAVES*NW-1:0]       = leaves_i;
  assign lvl[0][SPAN*NW-1:LEAVES*NW] = '0;

  generate
    for (genvar l = 0; l < DEPTH; l++) begin : g_level
      localparam int WO = enc_pkg::level_width(LEAVES, FANIN, l + 1);
      logic [WO*NW-1:0] comb_v;
      logic [WO*NW-1:0] stage_q;

      for (genvar j = 0; j < WO; j++) begin : g_node
        enc_node #(
          .CODE_W  (CODE_W),
          .FANIN   (FANIN),
          .PRIORITY(PRIORITY)
        ) u_node (
          .kids_i(lvl[l][j*FANIN*NW +: FANIN*NW]),
          .node_o(comb_v[j*NW +: NW])
        );
      end

      enc_stage_reg #(
        .WIDTH  (WO*NW),
        .USE_REG(enc_pkg::stage_has_reg(l, DEPTH, PIPE_LEVEL))
      ) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (comb_v),
        .q_o  (stage_q)
      );

      assign lvl[l+1][WO*NW-1:0]       = stage_q;
      assign lvl[l+1][SPAN*NW-1:WO*NW] = '0;
    end
  endgenerate

  assign root_o      = lvl[DEPTH][NW-1:0];
  assign unused_bits = ^lvl;

endmodule

// File: rtl/tree_encoder.sv
module tree_encoder #(
  parameter int CODE_W     = 3,
  parameter int PRIORITY   = 1,
  parameter int MAX_FANIN  = 2,
  parameter int PIPE_LEVEL = 2,
  parameter int IN_REG     = 1,
  parameter int OUT_REG    = 1,
  parameter int HAS_EN     = 1,
  localparam int LEAVES    = 1 << CODE_W,
  localparam int NW        = CODE_W + 2,
  localparam int DEPTH     = enc_pkg::tree_depth(LEAVES, MAX_FANIN),
  localparam int LATENCY   = IN_REG + OUT_REG + enc_pkg::pipe_regs(DEPTH, PIPE_LEVEL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEAVES-1:0] in_lines,
  input  logic              en,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);

  logic              en_eff;
  logic [LEAVES-1:0] gated;
  logic [LEAVES-1:0] lines_q;
  logic [LEAVES*NW-1:0] leaf_vec;
  logic [NW-1:0]     root;
  logic              res_valid;
  logic [CODE_W-1:0] res_code;
  logic              unused_sink;

  // Enable travels with its vector: a blanked vector becomes all-zero lines.
  assign en_eff = (HAS_EN != 0) ? en : 1'b1;
  assign gated  = en_eff ? in_lines : '0;

  enc_stage_reg #(
    .WIDTH  (LEAVES),
    .USE_REG(IN_REG != 0)
  ) u_in_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (gated),
    .q_o  (lines_q)
  );

  generate
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      assign leaf_vec[i*NW +: NW] = {lines_q[i], 1'b0, (lines_q[i] ? CODE_W'(i) : CODE_W'(0))};
    end
  endgenerate

  enc_reduce_tree #(
    .CODE_W    (CODE_W),
    .FANIN     (MAX_FANIN),
    .PIPE_LEVEL(PIPE_LEVEL),
    .PRIORITY  (PRIORITY)
  ) u_tree (
    .clk     (clk),
    .rst_n   (rst_n),
    .leaves_i(leaf_vec),
    .root_o  (root)
  );

  generate
    if (PRIORITY != 0) begin : g_prio
      assign res_valid = root[NW-1];
    end else begin : g_strict
      assign res_valid = root[NW-1] & ~root[NW-2];
    end
  endgenerate

  assign res_code    = res_valid ? root[CODE_W-1:0] : '0;
  assign unused_sink = ^{en, root[NW-2]};

  enc_stage_reg #(
    .WIDTH  (CODE_W + 1),
    .USE_REG(OUT_REG != 0)
  ) u_out_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({res_valid, res_code}),
    .q_o  ({valid_o, code_o})
  );

endmodule

// File: rtl/tree_encoder_checker.sv
module tree_encoder_checker #(
  parameter int CODE_W   = 3,
  parameter int PRIORITY = 1,
  parameter int HAS_EN   = 1,
  parameter int LATENCY  = 0,
  localparam int LEAVES  = 1 << CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEAVES-1:0] in_lines,
  input logic              en,
  input logic [CODE_W-1:0] code_o,
  input logic              valid_o
);

  // Delay line of the effective vectors, cleared by reset like the design.
  logic [LATENCY:0][LEAVES-1:0] hist;
  assign hist[0] = ((HAS_EN == 0) || en) ? in_lines : '0;

  generate
    for (genvar k = 1; k <= LATENCY; k++) begin : g_hist
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist[k] <= '0;
        else        hist[k] <= hist[k-1];
      end
    end
  endgenerate

  p_invalid_code_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (code_o == '0));

  p_valid_follows_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == ((PRIORITY != 0) ? (|hist[LATENCY]) : $onehot(hist[LATENCY])));

  p_highest_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((PRIORITY != 0) && valid_o) |-> ((hist[LATENCY] >> code_o) == LEAVES'(1)));

  p_single_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((PRIORITY == 0) && valid_o) |-> (hist[LATENCY] == (LEAVES'(1) << code_o)));

  always @(posedge clk) begin
    if (!rst_n && LATENCY > 0) begin
      p_reset_idle_r6: assert (!valid_o && code_o == '0);
    end
  end

endmodule

bind tree_encoder tree_encoder_checker #(
  .CODE_W  (CODE_W),
  .PRIORITY(PRIORITY),
  .HAS_EN  (HAS_EN),
  .LATENCY (LATENCY)
) u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_lines(in_lines),
  .en      (en),
  .code_o  (code_o),
  .valid_o (valid_o)
);

// File: tb/tree_encoder_bench.sv
module tree_encoder_bench;

  // Priority instance: 8 lines, fan-in 2 -> 3 levels, reg every 2 -> 2 stages,
  // plus input and output registers: latency 4.
  localparam int LAT_P = 4;
  // Strict instance: fan-in 3 -> 2 levels, no pipeline, output reg only: latency 1.
  localparam int LAT_N = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_lines = '0;
  logic       en = 1'b1;
  logic [2:0] code_p, code_n;
  logic       valid_p, valid_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  tree_encoder #(
    .CODE_W(3), .PRIORITY(1), .MAX_FANIN(2), .PIPE_LEVEL(2),
    .IN_REG(1), .OUT_REG(1), .HAS_EN(1)
  ) u_tree_encoder (
    .clk(clk), .rst_n(rst_n), .in_lines(in_lines), .en(en),
    .code_o(code_p), .valid_o(valid_p)
  );

  tree_encoder #(
    .CODE_W(3), .PRIORITY(0), .MAX_FANIN(3), .PIPE_LEVEL(0),
    .IN_REG(0), .OUT_REG(1), .HAS_EN(0)
  ) u_tree_encoder_strict (
    .clk(clk), .rst_n(rst_n), .in_lines(in_lines), .en(en),
    .code_o(code_n), .valid_o(valid_n)
  );

  function automatic logic [3:0] prio_ref(input logic [7:0] v, input logic e);
    logic [3:0] r;
    r = '0;
    if (e) for (int i = 0; i < 8; i++) if (v[i]) r = {1'b1, 3'(i)};
    return r;
  endfunction

  function automatic logic [3:0] strict_ref(input logic [7:0] v);
    logic [3:0] r;
    r = '0;
    if ($countones(v) == 1) for (int i = 0; i < 8; i++) if (v[i]) r = {1'b1, 3'(i)};
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual valid=%0b code=%0d, expected valid=%0b code=%0d",
               req, what, act[3], act[2:0], exp[3], exp[2:0]);
    end
  endtask

  // Apply one vector, hold it long enough for both instances, then compare.
  task automatic hold_and_check(input string req, input logic [7:0] v, input logic e);
    @(negedge clk);
    in_lines = v;
    en = e;
    repeat (LAT_P + 1) @(negedge clk);
    check(req, $sformatf("prio v=%02h en=%0b", v, e), {valid_p, code_p}, prio_ref(v, e));
    check(req, $sformatf("strict v=%02h", v), {valid_n, code_n}, strict_ref(v));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    in_lines = 8'hFF;
    en = 1'b1;
    repeat (3) @(negedge clk);
    check("R6", "prio during reset", {valid_p, code_p}, 4'h0);
    check("R6", "strict during reset", {valid_n, code_n}, 4'h0);
    rst_n = 1'b1;
    in_lines = '0;
    @(negedge clk);
    check("R6", "prio first cycle after reset", {valid_p, code_p}, 4'h0);
  endtask

  task automatic t_priority_cases();
    hold_and_check("R1", 8'h00, 1'b1);
    hold_and_check("R1", 8'h01, 1'b1);
    hold_and_check("R1", 8'h02, 1'b1);
    hold_and_check("R1", 8'h06, 1'b1);
    hold_and_check("R1", 8'h0F, 1'b1);
    hold_and_check("R1", 8'h81, 1'b1);
    hold_and_check("R1", 8'hFF, 1'b1);
    hold_and_check("R1", 8'h30, 1'b1);
  endtask

  task automatic t_strict_cases();
    for (int i = 0; i < 8; i++) hold_and_check("R2", 8'(1 << i), 1'b1);
    hold_and_check("R3", 8'h00, 1'b1);
    hold_and_check("R3", 8'h09, 1'b1);
    hold_and_check("R3", 8'hC0, 1'b1);
  endtask

  task automatic t_enable();
    hold_and_check("R5", 8'h40, 1'b0);
    hold_and_check("R5", 8'hA5, 1'b0);
    hold_and_check("R5", 8'h40, 1'b1);
  endtask

  task automatic t_latency_edge();
    @(negedge clk);
    in_lines = '0;
    en = 1'b1;
    repeat (LAT_P + 1) @(negedge clk);
    in_lines = 8'h20;
    repeat (LAT_P - 1) @(negedge clk);
    check("R4", "prio one cycle early", {valid_p, code_p}, 4'h0);
    @(negedge clk);
    check("R4", "prio on time", {valid_p, code_p}, 4'b1101);
  endtask

  task automatic t_stream();
    logic [7:0] sv [32];
    logic       se [32];
    logic [31:0] seed;
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 32; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      sv[i] = (i % 4 == 1) ? 8'(1 << seed[2:0]) : seed[23:16];
      se[i] = (i % 5 != 3);
    end
    for (int k = 0; k < 32 + LAT_P; k++) begin
      @(negedge clk);
      if (k >= LAT_P)
        check("R4", $sformatf("prio stream %0d", k - LAT_P), {valid_p, code_p},
              prio_ref(sv[k-LAT_P], se[k-LAT_P]));
      if (k >= LAT_N && k - LAT_N < 32)
        check("R5", $sformatf("strict stream %0d", k - LAT_N), {valid_n, code_n},
              strict_ref(sv[k-LAT_N]));
      if (k < 32) begin
        in_lines = sv[k];
        en = se[k];
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_priority_cases();
    t_strict_cases();
    t_enable();
    t_latency_edge();
    t_stream();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

endmodule